// File: doc/BRIEF.md
# Push Sequence Fusion Rewriter

This decode-stage block sits on a valid/ready stream of decoded micro-operations and looks for back-to-back register pushes. Each push normally lowers the stack pointer and then stores to it, so every push waits on the decrement before it. The block collects a run of two to four such pushes. It then emits one store per push, each addressed at a fixed negative offset from the stack pointer as it was before the run. These stores are followed by a single subtraction that lowers the stack pointer by the whole run's size. None of the stores depends on another store or on the pointer update, so a later stage can issue all of them together.

Ops that are not fusable leave unchanged and in order, as PASS ops. This covers a lone push, any op that is not a push, and a push whose source is the stack pointer itself. The output stream is stalled with backpressure. A synchronous flush drops any partially built run and any ops still waiting to leave. The stack grows downward, and each slot is `SLOT_BYTES` (default 8) bytes wide.

Top module: `push_fuse_rewriter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A run of n pushes (2 <= n <= `MAX_RUN`, default 4) leaves as n STORE ops (`out_op` = 1) in push order. The k-th store (k from 1) carries that push's source in `out_reg`, `out_imm` = -`SLOT_BYTES`*k, the push's payload, and `out_fused` = 1.
- R3: Right after the last store of a fused run comes exactly one SUB op (`out_op` = 2). It has `out_reg` = `SP_REG`, `out_imm` = +`SLOT_BYTES`*n (the amount subtracted), `out_payload` = 0 and `out_fused` = 1.
- R4: A run of exactly one push is not rewritten. It leaves as a PASS op (`out_op` = 0) with its own source and payload, `out_imm` = 0 and `out_fused` = 0.
- R5: An op that is not a push (`in_is_push` = 0) ends any pending run. It leaves as a PASS op with its source and payload unchanged and `out_fused` = 0, after the ops of that run.
- R6: A run closes as soon as it holds `MAX_RUN` pushes. A following push starts a new run.
- R7: A run closes when, in a cycle where the block is accepting and a run is pending, `in_valid` is 0.
- R8: A push whose source equals `SP_REG` is never fused. It closes the pending run before itself and leaves as a PASS op with `out_fused` = 0.
- R9: While `out_valid` is 1, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, the offered op stays the same in the next cycle. No op is dropped or repeated.
- R10: While `flush` is 1, `out_valid` and `in_ready` are 0. In the next cycle the pending run and every queued output are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous discard of pending run and queued ops |
| in_valid | input | 1 | Input op offered |
| in_ready | output | 1 | Block accepts the offered op |
| in_is_push | input | 1 | Offered op is a register push |
| in_src | input | REG_W | Source register of the offered op |
| in_payload | input | PAY_W | Opaque remainder of the offered op |
| out_valid | output | 1 | Output op offered |
| out_ready | input | 1 | Downstream takes the output op |
| out_op | output | 2 | 0 PASS, 1 STORE, 2 SUB |
| out_reg | output | REG_W | Source register (stack pointer for SUB) |
| out_imm | output | IMM_W | Signed offset for STORE, subtract amount for SUB |
| out_fused | output | 1 | Op produced by fusion |
| out_payload | output | PAY_W | Payload carried with PASS and STORE ops |

## Verification
Two functions can fall in the same cycle. A flush can land on an output that is stalled, or on the handshake of a run's final op. A stall can also arrive in the very cycle a run closes because it reached its length limit or because input went idle. The bench provokes these by mixing random flushes with random `out_ready` gaps, and by holding pushes back-to-back so that runs hit the length cap while the output is stalled. A behavioural queue model predicts `in_ready`, `out_valid` and every output field in each cycle, and each cycle is judged against it.

// File: rtl/push_fuse_pkg.sv
package push_fuse_pkg;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_STORE = 2'd1,
        OP_SUB   = 2'd2
    } fuse_op_e;

endpackage

// File: rtl/pfr_classify.sv
module pfr_classify #(
    parameter int REG_W  = 5,
    parameter int SP_REG = 31
) (
    input  logic             is_push,
    input  logic [REG_W-1:0] src,
    output logic             fusable,
    output logic             sp_push
);
    always_comb begin
        sp_push = is_push && (src == REG_W'(SP_REG));
        fusable = is_push && !sp_push;
    end
endmodule

// File: rtl/pfr_emit_seq.sv
module pfr_emit_seq
    import push_fuse_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int PAY_W      = 32,
    parameter int IMM_W      = 16,
    parameter int MAX_RUN    = 4,
    parameter int SLOT_BYTES = 8,
    parameter int SP_REG     = 31,
    localparam int CNT_W     = $clog2(MAX_RUN + 1),
    localparam int IDX_W     = $clog2(MAX_RUN + 3)
) (
    input  logic [CNT_W-1:0]              cnt,
    input  logic [IDX_W-1:0]              idx,
    input  logic [MAX_RUN-1:0][REG_W-1:0] regs,
    input  logic [MAX_RUN-1:0][PAY_W-1:0] pays,
    input  logic                          held_v,
    input  logic [REG_W-1:0]              held_reg,
    input  logic [PAY_W-1:0]              held_pay,
    output fuse_op_e                      op,
    output logic [REG_W-1:0]              reg_o,
    output logic signed [IMM_W-1:0]       imm,
    output logic [PAY_W-1:0]              pay_o,
    output logic                          fused,
    output logic                          last
);
    int               n_run;
    int               total;
    int               idx_i;
    int               cnt_i;
    logic [REG_W-1:0] sel_reg;
    logic [PAY_W-1:0] sel_pay;

    always_comb begin
        sel_reg = regs[0];
        sel_pay = pays[0];
        for (int i = 0; i < MAX_RUN; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_reg = regs[i];
                sel_pay = pays[i];
            end
        end
    end

    always_comb begin
        cnt_i = int'(cnt);
        idx_i = int'(idx);
        n_run = (cnt_i >= 2) ? cnt_i + 1 : cnt_i;
        total = n_run + (held_v ? 1 : 0);
        op    = OP_PASS;
        reg_o = held_reg;
        imm   = '0;
        pay_o = held_pay;
        fused = 1'b0;
        if (idx_i < n_run) begin
            if (cnt_i >= 2) begin
                fused = 1'b1;
                if (idx_i < cnt_i) begin
                    op    = OP_STORE;
                    reg_o = sel_reg;
                    pay_o = sel_pay;
                    imm   = IMM_W'(-(SLOT_BYTES * (idx_i + 1)));
                end else begin
                    op    = OP_SUB;
                    reg_o = REG_W'(SP_REG);
                    pay_o = '0;
                    imm   = IMM_W'(SLOT_BYTES * cnt_i);
                end
            end else begin
                reg_o = regs[0];
                pay_o = pays[0];
            end
        end
        last = (idx_i == total - 1);
    end
endmodule

// File: rtl/push_fuse_rewriter.sv
module push_fuse_rewriter
    import push_fuse_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int PAY_W      = 32,
    parameter int IMM_W      = 16,
    parameter int MAX_RUN    = 4,
    parameter int SLOT_BYTES = 8,
    parameter int SP_REG     = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_is_push,
    input  logic [REG_W-1:0] in_src,
    input  logic [PAY_W-1:0] in_payload,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_op,
    output logic [REG_W-1:0] out_reg,
    output logic [IMM_W-1:0] out_imm,
    output logic             out_fused,
    output logic [PAY_W-1:0] out_payload
);
    localparam int CNT_W = $clog2(MAX_RUN + 1);
    localparam int IDX_W = $clog2(MAX_RUN + 3);

    typedef struct packed {
        logic                          emit;
        logic [CNT_W-1:0]              cnt;
        logic [IDX_W-1:0]              idx;
        logic [MAX_RUN-1:0][REG_W-1:0] regs;
        logic [MAX_RUN-1:0][PAY_W-1:0] pays;
        logic                          held_v;
        logic [REG_W-1:0]              held_reg;
        logic [PAY_W-1:0]              held_pay;
    } state_t;

    state_t st_d, st_q;

    logic                    in_fusable;
    logic                    in_sp_push;
    fuse_op_e                seq_op;
    logic [REG_W-1:0]        seq_reg;
    logic signed [IMM_W-1:0] seq_imm;
    logic [PAY_W-1:0]        seq_pay;
    logic                    seq_fused;
    logic                    seq_last;

    pfr_classify #(
        .REG_W (REG_W),
        .SP_REG(SP_REG)
    ) u_classify (
        .is_push(in_is_push),
        .src    (in_src),
        .fusable(in_fusable),
        .sp_push(in_sp_push)
    );

    pfr_emit_seq #(
        .REG_W     (REG_W),
        .PAY_W     (PAY_W),
        .IMM_W     (IMM_W),
        .MAX_RUN   (MAX_RUN),
        .SLOT_BYTES(SLOT_BYTES),
        .SP_REG    (SP_REG)
    ) u_emit (
        .cnt     (st_q.cnt),
        .idx     (st_q.idx),
        .regs    (st_q.regs),
        .pays    (st_q.pays),
        .held_v  (st_q.held_v),
        .held_reg(st_q.held_reg),
        .held_pay(st_q.held_pay),
        .op      (seq_op),
        .reg_o   (seq_reg),
        .imm     (seq_imm),
        .pay_o   (seq_pay),
        .fused   (seq_fused),
        .last    (seq_last)
    );

    always_comb begin
        st_d        = st_q;
        in_ready    = !st_q.emit && !flush;
        out_valid   = st_q.emit && !flush;
        out_op      = seq_op;
        out_reg     = seq_reg;
        out_imm     = seq_imm;
        out_fused   = seq_fused;
        out_payload = seq_pay;

        if (flush) begin
            st_d = '0;
        end else if (st_q.emit) begin
            if (out_ready) begin
                if (seq_last) begin
                    st_d = '0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
        end else if (in_valid) begin
            if (in_fusable) begin
                for (int i = 0; i < MAX_RUN; i++) begin
                    if (st_q.cnt == CNT_W'(i)) begin
                        st_d.regs[i] = in_src;
                        st_d.pays[i] = in_payload;
                    end
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_W'(MAX_RUN - 1)) begin
                    st_d.emit = 1'b1;
                end
            end else begin
                st_d.held_v   = 1'b1;
                st_d.held_reg = in_src;
                st_d.held_pay = in_payload;
                st_d.emit     = 1'b1;
            end
        end else if (st_q.cnt != '0) begin
            st_d.emit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_sp_push;
    assign unused_sp_push = in_sp_push;
endmodule

// File: rtl/push_fuse_chk.sv
module push_fuse_chk #(
    parameter int REG_W  = 5,
    parameter int PAY_W  = 32,
    parameter int IMM_W  = 16,
    parameter int SP_REG = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_op,
    input logic [REG_W-1:0] out_reg,
    input logic [IMM_W-1:0] out_imm,
    input logic             out_fused,
    input logic [PAY_W-1:0] out_payload
);
    p_reset_idle_r1: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

    p_store_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 2'd1) |-> (out_fused && $signed(out_imm) < 0));

    p_sub_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 2'd2) |->
            (out_fused && out_reg == REG_W'(SP_REG) && $signed(out_imm) > 0));

    p_pass_unfused_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 2'd0) |-> (!out_fused && out_imm == '0));

    p_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst || flush)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_op) && $stable(out_reg) &&
             $stable(out_imm) && $stable(out_payload) && $stable(out_fused)));

    p_flush_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!out_valid && !in_ready));
endmodule

bind push_fuse_rewriter push_fuse_chk #(
    .REG_W (REG_W),
    .PAY_W (PAY_W),
    .IMM_W (IMM_W),
    .SP_REG(SP_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_op     (out_op),
    .out_reg    (out_reg),
    .out_imm    (out_imm),
    .out_fused  (out_fused),
    .out_payload(out_payload)
);

// File: tb/push_fuse_rewriter_tb.sv
module push_fuse_rewriter_tb;
    localparam int REG_W   = 5;
    localparam int PAY_W   = 32;
    localparam int IMM_W   = 16;
    localparam int MAX_RUN = 4;
    localparam int SLOT    = 8;
    localparam int SP      = 31;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_is_push = 1'b0;
    logic [REG_W-1:0] in_src = '0;
    logic [PAY_W-1:0] in_payload = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [1:0]       out_op;
    logic [REG_W-1:0] out_reg;
    logic [IMM_W-1:0] out_imm;
    logic             out_fused;
    logic [PAY_W-1:0] out_payload;

    always #2 clk = ~clk;

    push_fuse_rewriter u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_is_push(in_is_push),
        .in_src(in_src), .in_payload(in_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_reg(out_reg), .out_imm(out_imm), .out_fused(out_fused),
        .out_payload(out_payload)
    );

    typedef struct {
        int    op;
        int    rg;
        int    imm;
        int    pay;
        int    fused;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    run_reg[$];
    int    run_pay[$];
    int    vectors = 0;
    int    errors  = 0;
    bit    model_on = 0;
    bit    have_op = 0;
    bit    op_push;
    int    op_src;
    int    op_pay;

    function automatic item_t mk(int op, int rg, int imm, int pay, int fused, string tag);
        item_t t;
        t.op = op; t.rg = rg; t.imm = imm; t.pay = pay; t.fused = fused; t.tag = tag;
        return t;
    endfunction

    // Close the pending run: R2/R3 for fused runs, R4 for a lone push
    function automatic void close_run(string store_tag);
        int n = run_reg.size();
        if (n >= 2) begin
            for (int k = 0; k < n; k++)
                exp_q.push_back(mk(1, run_reg[k], -(SLOT * (k + 1)), run_pay[k], 1, store_tag));
            exp_q.push_back(mk(2, SP, SLOT * n, 0, 1, "R3"));
        end else if (n == 1) begin
            exp_q.push_back(mk(0, run_reg[0], 0, run_pay[0], 0, "R4"));
        end
        run_reg.delete();
        run_pay.delete();
    endfunction

    task automatic fail(string req, string what, int act, int expv);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, expv, $time);
    endtask

    // Reference model update at each rising edge
    always @(posedge clk) begin
        if (model_on && !rst) begin
            if (flush) begin
                exp_q.delete();
                run_reg.delete();
                run_pay.delete();
            end else if (exp_q.size() > 0) begin
                if (out_ready) void'(exp_q.pop_front());
            end else if (in_valid) begin
                have_op = 0;
                if (in_is_push && int'(in_src) != SP) begin
                    run_reg.push_back(int'(in_src));
                    run_pay.push_back(int'(in_payload));
                    if (run_reg.size() == MAX_RUN) close_run("R6");
                end else begin
                    close_run(in_is_push ? "R8" : "R5");
                    exp_q.push_back(mk(0, int'(in_src), 0, int'(in_payload), 0,
                                       in_is_push ? "R8" : "R5"));
                end
            end else if (run_reg.size() > 0) begin
                close_run("R7");
            end
        end
    end

    task automatic compare();
        bit    e_valid = !flush && exp_q.size() > 0;
        bit    e_ready = !flush && exp_q.size() == 0;
        bit    bad = 0;
        string tag = flush ? "R10" : "R9";
        vectors++;
        if (in_ready !== e_ready) begin fail(tag, "in_ready", int'(in_ready), int'(e_ready)); bad = 1; end
        if (out_valid !== e_valid) begin
            fail(exp_q.size() > 0 && !flush ? exp_q[0].tag : tag, "out_valid",
                 int'(out_valid), int'(e_valid));
            bad = 1;
        end
        if (!bad && e_valid) begin
            item_t e = exp_q[0];
            if (int'(out_op) != e.op) fail(e.tag, "out_op", int'(out_op), e.op);
            else if (int'(out_reg) != e.rg) fail(e.tag, "out_reg", int'(out_reg), e.rg);
            else if (int'($signed(out_imm)) != e.imm) fail(e.tag, "out_imm", int'($signed(out_imm)), e.imm);
            else if (int'(out_payload) != e.pay) fail(e.tag, "out_payload", int'(out_payload), e.pay);
            else if (int'(out_fused) != e.fused) fail(e.tag, "out_fused", int'(out_fused), e.fused);
        end
    endtask

    task automatic run_phase(int cycles, int p_valid, int p_push, int p_sp, int p_ready, int p_flush);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (!have_op && $urandom_range(99) < p_valid) begin
                have_op = 1;
                op_push = ($urandom_range(99) < p_push);
                op_src  = ($urandom_range(99) < p_sp) ? SP : int'($urandom_range(30));
                op_pay  = int'($urandom);
            end
            in_valid   = have_op;
            in_is_push = op_push;
            in_src     = REG_W'(op_src);
            in_payload = PAY_W'(op_pay);
            out_ready  = ($urandom_range(99) < p_ready);
            flush      = ($urandom_range(999) < p_flush);
            #1;
            compare();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle state after reset
        vectors++;
        if (out_valid !== 1'b0) fail("R1", "out_valid", int'(out_valid), 0);
        vectors++;
        if (in_ready !== 1'b1) fail("R1", "in_ready", int'(in_ready), 1);
        model_on = 1;
        run_phase(1500, 100, 95, 0, 100, 0);   // R2 R3 R6: long push streams
        run_phase(1500, 100, 70, 10, 60, 0);   // R5 R8 R9: mixed ops, stalls
        run_phase(1500, 60, 85, 5, 100, 0);    // R7 R4: idle gaps end runs
        run_phase(2000, 95, 85, 5, 50, 20);    // R10: flush against stalls
        run_phase(800, 100, 100, 0, 30, 0);    // R6 R9: capped runs under stall
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule